// File: doc/BRIEF.md
# Serial Keyboard Scancode Responder

This block plays the keyboard's side of a serial link. The host reports key events as a byte. The low seven bits select a key and the top bit marks a release. The block turns the key index into a keyboard code, keeps the release bit, and places the result in a byte queue. The host can also send command bytes on its transmit path. Two of these commands make the block queue a fixed reply: one reports the keyboard type and the other reports the layout.

Queued bytes go to the serial receiver in arrival order, one at a time. The oldest byte stays on the output until the receiver takes it. Only then is the next byte offered. The queue holds 256 bytes and uses wrapping read and write pointers. Bytes that arrive while the queue is full are dropped.

Top module: `kbd_responder`

## Requirements
- R1: After reset the queue is empty, `rx_valid` is 0 and `rx_data` is 0x00.
- R2: A key event `{rel, idx[6:0]}` queues the byte `{rel, code}`, where code = (7*idx + 127) mod 128. For example, index 0 gives 0x7F and index 1 gives 0x06. Bit 7 of the queued byte equals the event's bit 7.
- R3: Command byte 0x01 queues the single byte 0x05.
- R4: Command byte 0x07 queues the single byte 0x20.
- R5: Any command byte other than 0x01 and 0x07 queues nothing.
- R6: Bytes leave the queue in the order they entered. The pointers wrap, so queue contents stay correct after more than 256 bytes have passed through.
- R7: The queue holds at most 256 bytes. A byte offered while it holds 256 bytes is discarded, and this holds even if a take happens in the same cycle.
- R8: If a command with a reply and a key event arrive in the same cycle, the reply is queued ahead of the key code.
- R9: A take while the queue is empty changes nothing. `rx_data` keeps showing the last byte delivered.
- R10: `rx_valid` is 1 exactly when the queue is not empty, and `rx_data` is then the oldest byte. A take in one cycle presents the next byte after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Key event strobe |
| key_event | input | 8 | Bit 7 release flag, bits 6:0 key index |
| cmd_valid | input | 1 | Host command strobe |
| cmd_byte | input | 8 | Host command byte |
| rx_take | input | 1 | Receiver takes the offered byte |
| rx_valid | output | 1 | A byte is being offered |
| rx_data | output | 8 | Offered byte, or the last delivered byte when empty |

## Verification
A wrong pointer or count in this block shows at the ports in two ways. The drained byte sequence stops matching the arithmetic key map, or `rx_valid` drops early or late. Either shows up on the first take after the fault, or at the latest on the 257th byte when the queue reaches its full boundary. A fault in command decoding shows up in the same cycle as a queued reply that should not be there, or as a missing one. That is why every command value and every key index is swept, and the queue is driven across its full limit and through a wrap.

// File: rtl/kbd_resp_pkg.sv
package kbd_resp_pkg;
  localparam int KEY_MUL = 7;
  localparam int KEY_OFS = 127;
  localparam logic [7:0] CMD_RESET  = 8'h01;
  localparam logic [7:0] CMD_LAYOUT = 8'h07;
  localparam logic [7:0] RESP_TYPE  = 8'h05;
  localparam logic [7:0] RESP_LAYOUT = 8'h20;

  typedef struct packed {
    logic       vld;
    logic [7:0] data;
  } qbyte_t;

  function automatic logic [6:0] key_map(input logic [6:0] idx);
    int t;
    t = int'(idx) * KEY_MUL + KEY_OFS;
    return 7'(t % 128);
  endfunction

  function automatic qbyte_t cmd_reply(input logic [7:0] c);
    qbyte_t r;
    r.vld = 1'b1;
    case (c)
      CMD_RESET:  r.data = RESP_TYPE;
      CMD_LAYOUT: r.data = RESP_LAYOUT;
      default: begin
        r.vld = 1'b0;
        r.data = 8'h00;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/kbd_key_xlate.sv
module kbd_key_xlate
  import kbd_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_valid,
  input  logic [7:0] key_event,
  output logic       code_valid,
  output logic [7:0] code_out
);
  always_comb begin
    code_valid = key_valid;
    code_out   = {key_event[7], key_map(key_event[6:0])};
  end

  // R2: release flag passes through untouched
  a_r2_release_kept: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (code_valid && code_out[7] == key_event[7]));
endmodule

// File: rtl/kbd_cmd_decode.sv
module kbd_cmd_decode
  import kbd_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       resp_valid,
  output logic [7:0] resp_byte
);
  qbyte_t rep;
  always_comb begin
    rep        = cmd_reply(cmd_byte);
    resp_valid = cmd_valid && rep.vld;
    resp_byte  = rep.data;
  end

  a_r3_type_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'h01) |-> (resp_valid && resp_byte == 8'h05));
  a_r4_layout_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'h07) |-> (resp_valid && resp_byte == 8'h20));
  a_r5_unknown_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_byte != 8'h01 && cmd_byte != 8'h07) |-> !resp_valid);
endmodule

// File: rtl/kbd_byte_queue.sv
module kbd_byte_queue #(
  parameter int DEPTH = 256,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in0_valid,
  input  logic [W-1:0] in0_data,
  input  logic         in1_valid,
  input  logic [W-1:0] in1_data,
  input  logic         take,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic [W-1:0]  last_q;

  // named internal events
  logic          s0_v, s1_v, acc0, acc1, pop;
  logic [W-1:0]  s0_d, s1_d;

  always_comb begin
    if (in0_valid) begin
      s0_v = 1'b1;      s0_d = in0_data;
      s1_v = in1_valid; s1_d = in1_data;
    end else begin
      s0_v = in1_valid; s0_d = in1_data;
      s1_v = 1'b0;      s1_d = in1_data;
    end
    pop  = take && (count != '0);
    acc0 = s0_v && (count < FULL);
    acc1 = s1_v && ((count + CW'(1)) < FULL);
  end

  always_ff @(posedge clk) begin
    if (acc0) mem[wptr] <= s0_d;
    if (acc1) mem[wptr + AW'(1)] <= s1_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      count  <= '0;
      last_q <= '0;
    end else begin
      wptr  <= wptr + AW'(acc0) + AW'(acc1);
      count <= count + CW'(acc0) + CW'(acc1) - CW'(pop);
      if (pop) begin
        rptr   <= rptr + AW'(1);
        last_q <= mem[rptr];
      end
    end
  end

  always_comb begin
    out_valid = (count != '0);
    out_data  = out_valid ? mem[rptr] : last_q;
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL && !take) |=> count == FULL);
  a_r9_empty_take: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && take && !in0_valid && !in1_valid) |=> (count == '0 && $stable(out_data)));
  a_r10_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !in0_valid && !in1_valid) |=> count == $past(count) - CW'(1));
endmodule

// File: rtl/kbd_responder.sv
module kbd_responder #(
  parameter int DEPTH = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_valid,
  input  logic [7:0] key_event,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       rx_take,
  output logic       rx_valid,
  output logic [7:0] rx_data
);
  logic       code_valid, resp_valid;
  logic [7:0] code_out, resp_byte;

  kbd_key_xlate u_xlate (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_event(key_event),
    .code_valid(code_valid), .code_out(code_out));

  kbd_cmd_decode u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .resp_valid(resp_valid), .resp_byte(resp_byte));

  // R8: reply takes the first slot, key code the second
  kbd_byte_queue #(.DEPTH(DEPTH), .W(8)) u_q (
    .clk(clk), .rst_n(rst_n),
    .in0_valid(resp_valid), .in0_data(resp_byte),
    .in1_valid(code_valid), .in1_data(code_out),
    .take(rx_take), .out_valid(rx_valid), .out_data(rx_data));

  // R10: offered byte withdrawn only after a take
  a_r10_no_silent_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_valid) |-> $past(rx_take));
endmodule

// File: tb/kbd_responder_test.sv
module kbd_responder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_valid = 1'b0, cmd_valid = 1'b0, rx_take = 1'b0;
  logic [7:0] key_event = '0, cmd_byte = '0;
  logic rx_valid;
  logic [7:0] rx_data;
  int vectors = 0, miscompares = 0;

  always #2 clk = ~clk;

  kbd_responder uut (.*);

  function automatic logic [7:0] expect_key(input int ev);
    int r = 127;
    for (int i = 0; i < (ev % 128); i++) r = (r + 7) % 128;
    return 8'((ev & 128) | r);
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_key(input int ev);
    key_valid = 1'b1; key_event = 8'(ev);
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic send_cmd(input int c);
    cmd_valid = 1'b1; cmd_byte = 8'(c);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic take_expect(input string req, input logic [7:0] exp);
    check(req, {rx_valid, rx_data}, {1'b1, exp});
    rx_take = 1'b1;
    @(negedge clk);
    rx_take = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {rx_valid, rx_data}, 9'h000);

    // R2/R6/R7: fill with all 256 events, then overflow attempts
    for (int e = 0; e < 256; e++) send_key(e);
    send_key(0);
    send_cmd(1);
    rx_take = 1'b1; key_valid = 1'b1; key_event = 8'h05;   // R7: push at full with take
    @(negedge clk);
    rx_take = 1'b0; key_valid = 1'b0;
    check("R2", {rx_valid, rx_data}, {1'b1, expect_key(1)});
    for (int e = 1; e < 256; e++) take_expect("R2 R6", expect_key(e));
    check("R7", {1'b0, rx_valid}, 9'h000);
    last = expect_key(255);
    check("R9", {1'b0, rx_data}, {1'b0, last});
    rx_take = 1'b1;
    @(negedge clk);
    rx_take = 1'b0;
    check("R9", {rx_valid, rx_data}, {1'b0, last});

    // R3/R4/R5: sweep every command value
    for (int c = 0; c < 256; c++) begin
      send_cmd(c);
      if (c == 1) take_expect("R3", 8'h05);
      else if (c == 7) take_expect("R4", 8'h20);
      else check("R5", {rx_valid, rx_data}, {1'b0, last});
      if (c == 1) last = 8'h05;
      if (c == 7) last = 8'h20;
    end

    // R8: same-cycle reply and key
    key_valid = 1'b1; key_event = 8'h83; cmd_valid = 1'b1; cmd_byte = 8'h07;
    @(negedge clk);
    key_valid = 1'b0; cmd_valid = 1'b0;
    take_expect("R8", 8'h20);
    take_expect("R8", expect_key(8'h83));

    // R10: interleaved push and take after wrap
    for (int e = 0; e < 40; e++) begin
      send_key(e * 3);
      take_expect("R10 R6", expect_key(e * 3));
      check("R10", {1'b0, rx_valid}, 9'h000);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule